// File: doc/BRIEF.md
# Banked Memory Page Register

This block sits between an 8-bit CPU's 16-bit address bus and a 512 KB RAM. It splits the CPU address space into two 32 KB windows. The lower window is banked: a 4-bit page number chooses one of sixteen 32 KB pages of the RAM. The upper window is fixed and always reaches the final 32 KB page. Software changes the page with an I/O write to a single port. That port answers at two I/O addresses, 0x82 and its alias 0xA2.

The block samples the CPU bus strobes on a system clock. A small write-capture state machine has two states, `WR_IDLE` and `WR_HELD`. In `WR_IDLE`, a decoded I/O write loads the nibble on data bits 3:0 into the page register and takes the transition `WR_IDLE -> WR_HELD`. The machine stays in `WR_HELD` while that write strobe stays active. It takes `WR_HELD -> WR_IDLE` once IORQ or WR goes inactive. Because of this, each bus write loads the register exactly once, on its leading edge.

The register has two clears. The system reset clears it asynchronously. A separate active-low page-clear input clears it on a clock edge and does not depend on the system reset.

Top module: `bank_page_map`

## Requirements
- R1: While `rst_n` is low, and after it is released, `page_q` reads 0 until the register is written.
- R2: On the first clock edge where `iorq_n`=0, `wr_n`=0, `m1_n`=1 and `cpu_addr[7:0]`=0x82, the register loads `data_lo`. The new value appears on `page_q` after that edge.
- R3: The alias port 0xA2 loads the register in the same way. Address bit 5 and `cpu_addr[15:8]` are ignored in the port decode.
- R4: An I/O write to any other port address, for example 0x83, 0x92 or 0xC2, leaves `page_q` unchanged.
- R5: A write loads only once, at its leading edge. While the same strobe stays active (state `WR_HELD`), changes on `data_lo` do not alter `page_q`.
- R6: A cycle with `m1_n`=0 (interrupt acknowledge) does not alter `page_q`. Neither does a cycle with `iorq_n`=1 (memory cycle).
- R7: `page_clr_n`=0 sampled on a clock edge sets `page_q` to 0 after that edge, with `rst_n` held high. The clear takes priority over a simultaneous port write.
- R8: When `cpu_addr[15]`=0, `phys_addr[18:15]` equals `page_q`.
- R9: When `cpu_addr[15]`=1, `phys_addr[18:15]` is 4'b1111, the last 32 KB page, whatever `page_q` holds.
- R10: `phys_addr[14:0]` always equals `cpu_addr[14:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low system reset |
| page_clr_n | input | 1 | Synchronous active-low page-register clear |
| cpu_addr | input | 16 | CPU address bus |
| iorq_n | input | 1 | Active-low I/O request strobe |
| wr_n | input | 1 | Active-low write strobe |
| m1_n | input | 1 | Active-low opcode-fetch / interrupt-acknowledge marker |
| data_lo | input | 4 | CPU data bus bits 3:0 |
| phys_addr | output | 19 | Physical RAM address |
| page_q | output | 4 | Current page number |

## Verification
The assertions check the address mapping on every cycle: the lower window follows the page register, the upper window is pinned to all ones, and the offset bits pass straight through. They also check on every cycle that the page-clear input zeroes the register and that memory and acknowledge cycles leave it untouched. Three behaviours are shown only by the bench's scenarios: the port decode with its alias and its rejected neighbours, the once-per-strobe load while data changes under a held WR, and the return to zero after a mid-run reset.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;
endpackage

// File: rtl/bpm_port_decode.sv
module bpm_port_decode #(
    parameter int          PORT_W    = 8,
    parameter logic [7:0]  PORT_ADDR = 8'h82,
    parameter logic [7:0]  ALIAS_BIT = 8'h20
) (
    input  logic [PORT_W-1:0] port_addr,
    output logic              port_hit
);
    localparam logic [PORT_W-1:0] CARE = ~ALIAS_BIT[PORT_W-1:0];

    // Alias bit is masked out so both copies of the port decode alike.
    always_comb begin
        port_hit = ((port_addr & CARE) == (PORT_ADDR[PORT_W-1:0] & CARE));
    end
endmodule

// File: rtl/bpm_page_reg.sv
module bpm_page_reg
    import bank_map_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_clr_n,
    input  logic              port_hit,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic              m1_n,
    input  logic [PAGE_W-1:0] data_in,
    output logic [PAGE_W-1:0] page_q
);
    wr_state_t state_q, state_d;
    logic      io_wr_strobe;
    logic      load_en;

    always_comb begin
        io_wr_strobe = !iorq_n && !wr_n && m1_n;
        load_en      = (state_q == WR_IDLE) && io_wr_strobe && port_hit;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (load_en)       state_d = WR_HELD;
            WR_HELD: if (!io_wr_strobe) state_d = WR_IDLE;
            default:                    state_d = WR_IDLE;
        endcase
    end

    // Output register: the page number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           page_q <= '0;
        else if (!page_clr_n) page_q <= '0;
        else if (load_en)     page_q <= data_in;
    end
endmodule

// File: rtl/bpm_addr_map.sv
module bpm_addr_map #(
    parameter int PAGE_W = 4,
    parameter int WIN_W  = 15
) (
    input  logic [WIN_W:0]          cpu_addr,
    input  logic [PAGE_W-1:0]       page_q,
    output logic [PAGE_W+WIN_W-1:0] phys_addr
);
    localparam logic [PAGE_W-1:0] TOP_PAGE = '1;

    always_comb begin
        phys_addr[WIN_W-1:0] = cpu_addr[WIN_W-1:0];
        phys_addr[PAGE_W+WIN_W-1:WIN_W] = cpu_addr[WIN_W] ? TOP_PAGE : page_q;
    end
endmodule

// File: rtl/bank_page_map.sv
module bank_page_map #(
    parameter int         PAGE_W    = 4,
    parameter int         WIN_W     = 15,
    parameter int         PORT_W    = 8,
    parameter logic [7:0] PORT_ADDR = 8'h82,
    parameter logic [7:0] ALIAS_BIT = 8'h20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     page_clr_n,
    input  logic [WIN_W:0]           cpu_addr,
    input  logic                     iorq_n,
    input  logic                     wr_n,
    input  logic                     m1_n,
    input  logic [PAGE_W-1:0]        data_lo,
    output logic [PAGE_W+WIN_W-1:0]  phys_addr,
    output logic [PAGE_W-1:0]        page_q
);
    logic port_hit;

    bpm_port_decode #(
        .PORT_W(PORT_W), .PORT_ADDR(PORT_ADDR), .ALIAS_BIT(ALIAS_BIT)
    ) u_decode (
        .port_addr(cpu_addr[PORT_W-1:0]),
        .port_hit (port_hit)
    );

    bpm_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_clr_n(page_clr_n),
        .port_hit  (port_hit),
        .iorq_n    (iorq_n),
        .wr_n      (wr_n),
        .m1_n      (m1_n),
        .data_in   (data_lo),
        .page_q    (page_q)
    );

    bpm_addr_map #(.PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_map (
        .cpu_addr (cpu_addr),
        .page_q   (page_q),
        .phys_addr(phys_addr)
    );
endmodule

// File: rtl/bank_page_map_chk.sv
module bank_page_map_chk #(
    parameter int PAGE_W = 4,
    parameter int WIN_W  = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    page_clr_n,
    input logic [WIN_W:0]          cpu_addr,
    input logic                    iorq_n,
    input logic                    m1_n,
    input logic [PAGE_W+WIN_W-1:0] phys_addr,
    input logic [PAGE_W-1:0]       page_q
);
    assert_low_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[WIN_W] |-> phys_addr[PAGE_W+WIN_W-1:WIN_W] == page_q);

    assert_high_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[WIN_W] |-> phys_addr[PAGE_W+WIN_W-1:WIN_W] == {PAGE_W{1'b1}});

    assert_offset_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]);

    assert_page_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !page_clr_n |=> page_q == '0);

    assert_non_io_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((iorq_n || !m1_n) && page_clr_n) |=> $stable(page_q));
endmodule

bind bank_page_map bank_page_map_chk #(.PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_clr_n(page_clr_n),
    .cpu_addr  (cpu_addr),
    .iorq_n    (iorq_n),
    .m1_n      (m1_n),
    .phys_addr (phys_addr),
    .page_q    (page_q)
);

// File: tb/bank_page_map_bench.sv
`timescale 1ns/1ps
module bank_page_map_bench;
    typedef struct {
        string       tag;
        logic [3:0]  page;
        logic [18:0] phys;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        page_clr_n = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        iorq_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        m1_n = 1'b1;
    logic [3:0]  data_lo = 4'h0;
    logic [18:0] phys_addr;
    logic [3:0]  page_q;

    exp_t        sbq[$];
    int          total = 0;
    int          bad = 0;
    logic [3:0]  model_page = 4'h0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    bank_page_map u_bank_page_map (
        .clk(clk), .rst_n(rst_n), .page_clr_n(page_clr_n), .cpu_addr(cpu_addr),
        .iorq_n(iorq_n), .wr_n(wr_n), .m1_n(m1_n), .data_lo(data_lo),
        .phys_addr(phys_addr), .page_q(page_q)
    );

    function automatic logic [18:0] map_of(input logic [15:0] a, input logic [3:0] p);
        return {(a[15] ? 4'hF : p), a[14:0]};
    endfunction

    task automatic bus(input logic [15:0] a, input logic iq, input logic w,
                       input logic m1, input logic [3:0] d);
        cpu_addr = a; iorq_n = iq; wr_n = w; m1_n = m1; data_lo = d;
    endtask

    // Push the expectation for the current half cycle, then move to the next cycle
    task automatic expect_step(input string tag);
        exp_t e;
        e.tag = tag; e.page = model_page; e.phys = map_of(cpu_addr, model_page);
        sbq.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [3:0] d,
                            input bit takes, input string tag);
        bus(a, 1'b0, 1'b0, 1'b1, d);
        expect_step(tag);
        if (takes) model_page = d;
        expect_step(tag);
        bus(16'h1234, 1'b1, 1'b1, 1'b1, 4'h0);
        expect_step(tag);
    endtask

    // Monitor: compares popped items against the outputs at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            total++;
            if (page_q !== e.page || phys_addr !== e.phys) begin
                bad++;
                $display("FAIL %s: page=%h phys=%h expected page=%h phys=%h",
                         e.tag, page_q, phys_addr, e.page, e.phys);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_addr = 16'h1234;
        repeat (2) @(posedge clk); #1;
        expect_step("R1 during reset");
        rst_n = 1'b1;
        expect_step("R1 after release");

        io_write(16'h0082, 4'h5, 1'b1, "R2 load via 0x82");
        bus(16'h4ABC, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R8 low window");
        bus(16'hC123, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R9 high window");
        bus(16'h7FFF, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R10 offset pass");

        io_write(16'h7FA2, 4'hA, 1'b1, "R3 alias with upper bits");
        io_write(16'h0083, 4'h3, 1'b0, "R4 port 0x83");
        io_write(16'h0092, 4'h3, 1'b0, "R4 port 0x92");
        io_write(16'h00C2, 4'h3, 1'b0, "R4 port 0xC2");

        // R5: data changes while WR stays low
        bus(16'h0082, 1'b0, 1'b0, 1'b1, 4'h4); expect_step("R5 lead");
        model_page = 4'h4;
        data_lo = 4'h9; expect_step("R5 held data change");
        data_lo = 4'h2; expect_step("R5 held data change");
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R5 release");

        // R6: acknowledge and memory cycles
        bus(16'h0082, 1'b0, 1'b0, 1'b0, 4'hC); expect_step("R6 m1 low");
        expect_step("R6 m1 low");
        bus(16'h0082, 1'b1, 1'b0, 1'b1, 4'hC); expect_step("R6 memory write");
        expect_step("R6 memory write");
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R6 idle");

        // Boundary: page 15 against the fixed window
        io_write(16'h0082, 4'hF, 1'b1, "R2 load 0xF");
        bus(16'h7FFF, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R8 page 15 top");
        bus(16'h8000, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R9 window base");

        // R7: dedicated clear
        page_clr_n = 1'b0; expect_step("R7 clear sampled");
        model_page = 4'h0;
        page_clr_n = 1'b1; expect_step("R7 cleared");
        io_write(16'h0082, 4'h6, 1'b1, "R7 reload");
        bus(16'h0082, 1'b0, 1'b0, 1'b1, 4'h9); page_clr_n = 1'b0;
        expect_step("R7 clear beats write");
        model_page = 4'h0;
        page_clr_n = 1'b1;
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 4'h0); expect_step("R7 clear beats write");

        // R1: mid-run reset
        io_write(16'h00A2, 4'hB, 1'b1, "R3 alias load");
        #1 rst_n = 1'b0; model_page = 4'h0;
        @(posedge clk); #1;
        expect_step("R1 mid-run reset");
        rst_n = 1'b1;
        expect_step("R1 after mid-run reset");

        @(posedge clk); #1;
        wait (sbq.size() == 0);
        @(posedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule